// File: doc/BRIEF.md
# Sequential Modular Exponentiation Unit

This block raises a base X to an exponent E modulo a modulus N with binary square-and-multiply. Every product is reduced modulo N as soon as it is formed, so no intermediate value reaches N and the full power is never held. A caller places X, E and N on the inputs and pulses `start`. The unit then runs by itself. It pulses `done` for one cycle when the result `y` is ready.

The modular products come from a radix-2 interleaved multiplier. It scans the multiplier operand from its top bit down. At each step it doubles the accumulator, adds the multiplicand when the scanned bit is set, and applies a conditional subtraction of N after each of those two moves. One product takes `W` cycles.

A parameter selects one of two exponent schedules:

- **Low-to-high (right-to-left):** the exponent is scanned from bit 0 upward. The squaring of the running power S and the conditional update of the result run on two multipliers at the same time. The exponent bit acts as the write enable for the result update.
- **High-to-low (left-to-right):** the exponent is scanned from the top bit down. A single multiplier first squares the result and then, only when the bit is set, multiplies the result by X.

Top module: `modexp`

## Requirements
- R1: For any X < N with N ≥ 2 and any E, `y` at `done` equals X^E mod N, in both schedules (`LEFT_TO_RIGHT` = 0 or 1).
- R2: While a computation runs, the result register and every multiplier accumulator stay strictly below N.
- R3: E = 0 gives `y` = 1, even when X = 0.
- R4: A `start` pulse that arrives while a computation runs is ignored. The result and the latency are those of the operation already in progress.
- R5: `done` is high for exactly one cycle per operation, and `y` keeps the result until the next accepted `start`. After reset, `done` is 0 and `y` is 0.
- R6: Counting clock edges after the edge that accepts `start`, `done` rises at edge `EXP_W*W` in the low-to-high schedule. In the high-to-low schedule it rises at edge `W*(EXP_W + number of ones in E)`.
- R7: 3^19 mod 11 gives 4, and 7^12 mod 11 gives 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only when the unit is idle |
| x | input | W | Base, below N |
| e | input | EXP_W | Exponent |
| n | input | W | Modulus, at least 2 |
| done | output | 1 | One-cycle pulse when the result is valid |
| y | output | W | Result X^E mod N |

## Verification
The bench builds two instances side by side from the same stimulus:

- one with `LEFT_TO_RIGHT=0` and one with `LEFT_TO_RIGHT=1`;
- both with `W=16` and `EXP_W=16`.

The full 16-bit range lets moduli near 65535 drive the doubled accumulator into its extra top bit, where the conditional subtraction must act.

Running both schedules on the same stimulus lets the bench check each latency formula, since the high-to-low cycle count depends on the exponent's weight and the low-to-high count does not. Directed cases cover:

- an all-ones exponent;
- E = 0 and E = 1;
- N = 2;
- the two worked examples.

// File: rtl/modexp.sv
module modexp #(
  parameter int W             = 16,
  parameter int EXP_W         = 16,
  parameter bit LEFT_TO_RIGHT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     x,
  input  logic [EXP_W-1:0] e,
  input  logic [W-1:0]     n,
  output logic             done,
  output logic [W-1:0]     y
);
  localparam int IW = (EXP_W > 1) ? $clog2(EXP_W) : 1;
  localparam int JW = (W > 1) ? $clog2(W) : 1;

  // one interleaved step: acc*2 (+a) with reduction after each move
  function automatic logic [W-1:0] mm_step(input logic [W-1:0] acc,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] m,
                                           input logic         b);
    logic [W:0] t;
    t = {acc, 1'b0};
    if (t >= {1'b0, m}) t = t - {1'b0, m};
    if (b) t = t + {1'b0, a};
    if (t >= {1'b0, m}) t = t - {1'b0, m};
    return t[W-1:0];
  endfunction

  logic             busy, mul_ph;
  logic [W-1:0]     y_r, s_r, n_r, acc0, acc1;
  logic [EXP_W-1:0] e_r;
  logic [IW-1:0]    i_r;
  logic [JW-1:0]    j_r;

  logic [W-1:0] b0, nxt0, nxt1;
  logic         ebit, last_step, last_iter;

  assign ebit      = e_r[i_r];
  assign b0        = (LEFT_TO_RIGHT && !mul_ph) ? y_r : s_r;
  assign nxt0      = mm_step(acc0, y_r, n_r, b0[j_r]);
  assign nxt1      = mm_step(acc1, s_r, n_r, s_r[j_r]);
  assign last_step = (j_r == '0);
  assign last_iter = LEFT_TO_RIGHT ? (i_r == '0) : (i_r == IW'(EXP_W-1));
  assign y         = y_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mul_ph <= 1'b0;
      y_r    <= '0;
      s_r    <= '0;
      n_r    <= '0;
      e_r    <= '0;
      acc0   <= '0;
      acc1   <= '0;
      i_r    <= '0;
      j_r    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          mul_ph <= 1'b0;
          y_r    <= W'(1);
          s_r    <= x;
          n_r    <= n;
          e_r    <= e;
          acc0   <= '0;
          acc1   <= '0;
          i_r    <= LEFT_TO_RIGHT ? IW'(EXP_W-1) : '0;
          j_r    <= JW'(W-1);
        end
      end else if (!last_step) begin
        acc0 <= nxt0;
        acc1 <= nxt1;
        j_r  <= j_r - 1'b1;
      end else begin
        acc0 <= '0;
        acc1 <= '0;
        j_r  <= JW'(W-1);
        if (!LEFT_TO_RIGHT) begin
          if (ebit) y_r <= nxt0;
          s_r <= nxt1;
          if (last_iter) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            i_r <= i_r + 1'b1;
          end
        end else begin
          y_r <= nxt0;
          if (!mul_ph && ebit) begin
            mul_ph <= 1'b1;
          end else begin
            mul_ph <= 1'b0;
            if (last_iter) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              i_r <= i_r - 1'b1;
            end
          end
        end
      end
    end
  end

  AST_Y_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (y_r < n_r)); // R2
  AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc0 < n_r) && (acc1 < n_r)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(n_r) && $stable(e_r) && $stable(busy)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R6
  AST_ZERO_EXP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && e_r == '0) |-> (y_r == W'(1))); // R3
endmodule

// File: tb/tb_modexp.sv
module tb_modexp;
  localparam int W = 16;
  localparam int EXP_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] x = '0, n = '0;
  logic [EXP_W-1:0] e = '0;
  logic done_a, done_b;
  logic [W-1:0] y_a, y_b;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  modexp #(.W(W), .EXP_W(EXP_W), .LEFT_TO_RIGHT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x(x), .e(e), .n(n),
    .done(done_a), .y(y_a));

  modexp #(.W(W), .EXP_W(EXP_W), .LEFT_TO_RIGHT(1'b1)) dut_l2r (
    .clk(clk), .rst_n(rst_n), .start(start), .x(x), .e(e), .n(n),
    .done(done_b), .y(y_b));

  function automatic longint ref_pow(longint bx, longint ex, longint m);
    longint r = 1, b = bx % m;
    for (int k = 0; k < EXP_W; k++) begin
      if ((ex >> k) & 1) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r % m;
  endfunction

  function automatic int ones(logic [EXP_W-1:0] v);
    int c = 0;
    for (int k = 0; k < EXP_W; k++) c += v[k];
    return c;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one operation on both instances; optional second start while busy
  task automatic run(input logic [W-1:0] xi, input logic [EXP_W-1:0] ei,
                     input logic [W-1:0] ni, input bit poke, input string tag);
    int c = 0, lat_a = -1, lat_b = -1;
    longint exp_y;
    logic [W-1:0] ra = '0, rb = '0;
    exp_y = ref_pow(longint'(xi), longint'(ei), longint'(ni));
    @(negedge clk);
    x = xi; e = ei; n = ni; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while ((lat_a < 0 || lat_b < 0) && c < 2000) begin
      @(negedge clk);
      c++;
      if (poke && c == 5) begin
        x = ni - 1'b1; e = ~ei; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done_a && lat_a < 0) begin lat_a = c; ra = y_a; end
      if (done_b && lat_b < 0) begin lat_b = c; rb = y_b; end
    end
    start = 1'b0;
    if (lat_a < 0 || lat_b < 0) begin
      checks++; fails++;
      $display("FAIL R6 %s watchdog: no done actual=%0d expected=done", tag, c);
    end
    chk({"R1 r2l ", tag}, ra, exp_y);
    chk({"R1 l2r ", tag}, rb, exp_y);
    chk({"R6 r2l latency ", tag}, lat_a, EXP_W*W);
    chk({"R6 l2r latency ", tag}, lat_b, W*(EXP_W + ones(ei)));
  endtask

  initial begin
    #3000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R5 reset done", done_a | done_b, 0);
    chk("R5 reset y", y_a | y_b, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(16'd3, 16'd19, 16'd11, 1'b0, "3^19 mod 11");
    chk("R7 3^19 mod 11", y_a, 4);
    run(16'd7, 16'd12, 16'd11, 1'b0, "7^12 mod 11");
    chk("R7 7^12 mod 11", y_b, 5);
    run(16'd1234, 16'd0, 16'd65521, 1'b0, "E=0");
    chk("R3 E=0 result", y_a, 1);
    run(16'd0, 16'd0, 16'd7, 1'b0, "X=0 E=0");
    chk("R3 0^0 result", y_b, 1);
    run(16'd65534, 16'hFFFF, 16'd65535, 1'b0, "all-ones E");
    run(16'd1, 16'd1, 16'd2, 1'b0, "N=2");
    run(16'd40000, 16'd1, 16'd65535, 1'b0, "E=1");

    // R5: result held after done, no second pulse
    repeat (4) @(negedge clk);
    chk("R5 held y r2l", y_a, 40000);
    chk("R5 held y l2r", y_b, 40000);
    chk("R5 done low", done_a | done_b, 0);

    // R4: start while busy is ignored (checked inside run by result and latency)
    run(16'd3, 16'd19, 16'd11, 1'b1, "R4 start while busy");
    chk("R4 result kept", y_a, 4);

    for (int t = 0; t < 40; t++) begin
      logic [W-1:0] nn, xx;
      logic [EXP_W-1:0] ee;
      nn = W'($urandom);
      if (nn < 2) nn = 2;
      xx = W'($urandom % nn);
      ee = EXP_W'($urandom);
      run(xx, ee, nn, 1'b0, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule